// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synthesizable synchronous static RAM with 18-bit words and a register-to-register pipeline. Each rising clock edge samples the command: chip select, write enable, two byte-write enables and the address. A read puts the addressed word on the output in the cycle after its address. A write is a late write. Its data is taken from the data input one edge after its address and is held in a one-entry pending-write buffer. That buffer is written into the storage array only when the next write's data arrives. A read whose address matches the pending entry gets the pending bytes merged over the stored word, so a read that follows a write is coherent without a stall.

The bidirectional bus is split into a data input, a registered data output and an output-drive flag that stands for the tri-state enable. The output enable and the sleep input act on the drive flag without waiting for a clock edge. Sleep also blocks any command from taking effect. The depth is a parameter, so a small array can be used for simulation while the word format stays fixed.

Top module: `lw_sram_core`

## Requirements
- R1: While reset is high, and after it is released with no command issued, dout_en is 0 and the pending-write buffer is empty.
- R2: A read is sampled at edge k when sel_n=0, wr_n=1 and sleep_i=0. During the cycle after edge k+1, dout holds the latest value written to that address, and dout_en is 1 when oe_n=0.
- R3: A write is sampled at edge k when sel_n=0, wr_n=0 and sleep_i=0. Its data is the value of din at edge k+1.
- R4: bwa_n=0 writes byte a (bits 8:0) and bwb_n=0 writes byte b (bits 17:9). A byte whose enable is 1 keeps its stored value.
- R5: A cycle sampled with sel_n=1 leaves dout_en at 0 during the cycle after the next edge.
- R6: oe_n=1 holds dout_en at 0 at all times, which makes a read a dummy read. oe_n acts without waiting for a clock edge: a change during an output cycle moves dout_en at once.
- R7: During the data cycle of a write (after edge k+1), dout_en is 0.
- R8: While sleep_i=1, dout_en is 0 at once. A command sampled while sleep_i=1 has no effect. A write whose data edge sees sleep_i=1 is dropped.
- R9: A read of the address of a write that is not yet committed returns the pending bytes merged over the stored word. This includes a read issued at the data edge of that write.
- R10: Back-to-back writes each commit exactly once and in issue order. After several writes to one address, a read returns the combination the writes produce in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Sleep: blocks commands and output drive |
| sel_n | input | 1 | Chip select, active low, sampled |
| wr_n | input | 1 | Write enable, active low, sampled |
| bwa_n | input | 1 | Byte a (bits 8:0) write enable, active low |
| bwb_n | input | 1 | Byte b (bits 17:9) write enable, active low |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| oe_n | input | 1 | Output enable, active low, not clocked |
| din | input | 18 | Write data, taken one edge after its address |
| dout | output | 18 | Read data |
| dout_en | output | 1 | Output drive flag (tri-state enable) |

## Verification
Reads are tried in several positions. A read two or more cycles after a write comes from the array. A read issued at a write's data edge must be served by forwarding. A read behind a partial write shows whether the byte lanes are merged or overwritten. Runs of writes to one address, some full and some partial, followed by reads from the buffer and then from the array, show any lost, doubled or reordered commit. Dummy reads, sleep during the address edge or the data edge, and mid-cycle toggles of oe_n and sleep_i separate sampled control from asynchronous control.

// File: rtl/lws_pkg.sv
package lws_pkg;
  localparam int BYTE_W = 9;
  localparam int NLANE  = 2;
  localparam int WORD_W = BYTE_W * NLANE;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic [NLANE-1:0] be;
  } lws_op_t;
endpackage

// File: rtl/lws_ctrl.sv
module lws_ctrl
  import lws_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic [NLANE-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  output lws_op_t          op_q,
  output logic [AW-1:0]    addr_q,
  output logic             out_v_q
);
  logic live;
  assign live = ~sleep_i & ~sel_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= '0;
      out_v_q <= 1'b0;
    end else begin
      op_q.rd <= live & wr_n;
      op_q.wr <= live & ~wr_n;
      op_q.be <= ~bw_n;
      out_v_q <= op_q.rd;
    end
    addr_q <= addr;
  end
endmodule

// File: rtl/lws_wbuf.sv
module lws_wbuf
  import lws_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [AW-1:0]     cap_addr,
  input  logic [NLANE-1:0]  cap_be,
  input  logic [WORD_W-1:0] cap_data,
  input  logic              look,
  input  logic [AW-1:0]     look_addr,
  output logic              cmt_en,
  output logic [AW-1:0]     cmt_addr,
  output logic [NLANE-1:0]  cmt_be,
  output logic [WORD_W-1:0] cmt_data,
  output logic [NLANE-1:0]  fwd_be_q,
  output logic [WORD_W-1:0] fwd_data_q
);
  logic              pend_v;
  logic [AW-1:0]     pend_addr;
  logic [NLANE-1:0]  pend_be;
  logic [WORD_W-1:0] pend_data;
  logic              hit;

  assign hit      = pend_v && (pend_addr == look_addr);
  assign cmt_en   = cap & pend_v;
  assign cmt_addr = pend_addr;
  assign cmt_be   = pend_be;
  assign cmt_data = pend_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v   <= 1'b0;
      fwd_be_q <= '0;
    end else begin
      if (cap) pend_v <= 1'b1;
      if (look) fwd_be_q <= hit ? pend_be : '0;
    end
    if (cap) begin
      pend_addr <= cap_addr;
      pend_be   <= cap_be;
      pend_data <= cap_data;
    end
    if (look) fwd_data_q <= pend_data;
  end
endmodule

// File: rtl/lws_array.sv
module lws_array
  import lws_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic              clk,
  input  logic              wen,
  input  logic [AW-1:0]     waddr,
  input  logic [NLANE-1:0]  wbe,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ren,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata_q
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wen && wbe[g]) mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
      if (ren) rd_q <= mem[raddr];
    end

    assign rdata_q[g*BYTE_W +: BYTE_W] = rd_q;
  end
endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
  import lws_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_i,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              bwa_n,
  input  logic              bwb_n,
  input  logic [AW-1:0]     addr,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);
  lws_op_t           op_q;
  logic [AW-1:0]     addr_q;
  logic              out_v_q;
  logic              cap;
  logic              cmt_en;
  logic [AW-1:0]     cmt_addr;
  logic [NLANE-1:0]  cmt_be;
  logic [WORD_W-1:0] cmt_data;
  logic [NLANE-1:0]  fwd_be_q;
  logic [WORD_W-1:0] fwd_data_q;
  logic [WORD_W-1:0] mem_q;

  lws_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .sleep_i (sleep_i),
    .sel_n   (sel_n),
    .wr_n    (wr_n),
    .bw_n    ({bwb_n, bwa_n}),
    .addr    (addr),
    .op_q    (op_q),
    .addr_q  (addr_q),
    .out_v_q (out_v_q)
  );

  // Write data is captured at the edge after its address.
  assign cap = op_q.wr & ~sleep_i;

  lws_wbuf #(.AW(AW)) u_wbuf (
    .clk        (clk),
    .rst        (rst),
    .cap        (cap),
    .cap_addr   (addr_q),
    .cap_be     (op_q.be),
    .cap_data   (din),
    .look       (op_q.rd),
    .look_addr  (addr_q),
    .cmt_en     (cmt_en),
    .cmt_addr   (cmt_addr),
    .cmt_be     (cmt_be),
    .cmt_data   (cmt_data),
    .fwd_be_q   (fwd_be_q),
    .fwd_data_q (fwd_data_q)
  );

  lws_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk     (clk),
    .wen     (cmt_en),
    .waddr   (cmt_addr),
    .wbe     (cmt_be),
    .wdata   (cmt_data),
    .ren     (op_q.rd),
    .raddr   (addr_q),
    .rdata_q (mem_q)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_merge
    assign dout[g*BYTE_W +: BYTE_W] = fwd_be_q[g] ? fwd_data_q[g*BYTE_W +: BYTE_W]
                                                  : mem_q[g*BYTE_W +: BYTE_W];
  end

  assign dout_en = out_v_q & ~oe_n & ~sleep_i;
endmodule

// File: rtl/lws_check.sv
module lws_check (
  input logic clk,
  input logic rst,
  input logic sleep_i,
  input logic sel_n,
  input logic wr_n,
  input logic oe_n,
  input logic dout_en
);
  a_r6_oe_blocks_drive: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dout_en);

  a_r8_sleep_blocks_drive: assert property (@(posedge clk) disable iff (rst)
    sleep_i |-> !dout_en);

  a_r8_sleep_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    sleep_i |-> ##2 !dout_en);

  a_r5_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    sel_n |-> ##2 !dout_en);

  a_r7_write_data_quiet: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_n) |-> ##2 !dout_en);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && wr_n && !sleep_i) |-> ##2 (dout_en == (!oe_n && !sleep_i)));
endmodule

bind lw_sram_core lws_check u_lws_check (
  .clk     (clk),
  .rst     (rst),
  .sleep_i (sleep_i),
  .sel_n   (sel_n),
  .wr_n    (wr_n),
  .oe_n    (oe_n),
  .dout_en (dout_en)
);

// File: tb/lw_sram_core_test.sv
module lw_sram_core_test;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [17:0] JUNK = 18'h15555;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleep_i = 1'b0;
  logic          sel_n = 1'b1;
  logic          wr_n = 1'b1;
  logic          bwa_n = 1'b1;
  logic          bwb_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          oe_n = 1'b0;
  logic [17:0]   din = '0;
  logic [17:0]   dout;
  logic          dout_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench state for the pipelined op task
  bit          pw_v = 0;
  logic [AW-1:0] pw_a;
  logic [1:0]  pw_be_n;
  logic [17:0] pw_d;
  int          ck_kind = 0;  // 0 none, 1 expect quiet, 2 expect data
  logic [17:0] ck_exp;
  string       ck_req;
  logic [17:0] model [DEPTH];

  always #4 clk = ~clk;

  lw_sram_core #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .sel_n(sel_n), .wr_n(wr_n),
    .bwa_n(bwa_n), .bwb_n(bwb_n), .addr(addr), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  // byte a = bits 8:0 (be_n[0]), byte b = bits 17:9 (be_n[1])
  function automatic logic [17:0] merge(logic [17:0] old, logic [17:0] nw, logic [1:0] be_n);
    merge = old;
    if (!be_n[0]) merge[8:0]  = nw[8:0];
    if (!be_n[1]) merge[17:9] = nw[17:9];
  endfunction

  task automatic check(bit ok, string req, string what, logic [17:0] act, logic [17:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One command cycle; checks the output of the previous command.
  task automatic op(bit is_sel, bit is_wr, logic [1:0] be_n, logic [AW-1:0] a,
                    logic [17:0] wd, string req);
    logic [17:0] e;
    sel_n = !is_sel; wr_n = !is_wr; bwa_n = be_n[0]; bwb_n = be_n[1]; addr = a;
    if (pw_v) begin
      din = pw_d;
      model[pw_a] = merge(model[pw_a], pw_d, pw_be_n);
    end else begin
      din = JUNK;
    end
    e = model[a];
    tick();
    if (ck_kind == 2) begin
      check(dout_en === 1'b1, ck_req, "read drive", {17'b0, dout_en}, 18'd1);
      check(dout === ck_exp, ck_req, "read data", dout, ck_exp);
    end else if (ck_kind == 1) begin
      check(dout_en === 1'b0, ck_req, "bus quiet", {17'b0, dout_en}, 18'd0);
    end
    ck_kind = (is_sel && !is_wr) ? 2 : 1;
    ck_exp = e;
    ck_req = req;
    pw_v = is_sel && is_wr;
    pw_a = a; pw_be_n = be_n; pw_d = wd;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [1:0] be_n, logic [17:0] d, string req);
    op(1, 1, be_n, a, d, req);
  endtask
  task automatic rd(logic [AW-1:0] a, string req);
    op(1, 0, 2'b11, a, JUNK, req);
  endtask
  task automatic nop(string req);
    op(0, 0, 2'b11, '0, JUNK, req);
  endtask
  task automatic settle();
    nop("R5"); nop("R5");
    ck_kind = 0; pw_v = 0;
  endtask

  task automatic t_reset();
    check(dout_en === 1'b0, "R1", "after reset", {17'b0, dout_en}, 18'd0);
    nop("R1");
    check(dout_en === 1'b0, "R1", "idle after reset", {17'b0, dout_en}, 18'd0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < 8; i++) wr(AW'(i), 2'b00, 18'(i * 18'h0931 + 18'h00107), "R3");
    nop("R7");
    nop("R5");
    for (int i = 0; i < 8; i++) rd(AW'(i), "R2");
    nop("R2");
    settle();
  endtask

  task automatic t_forward();
    wr(10, 2'b00, 18'h2A5A5, "R7");
    rd(10, "R9");                       // read at data edge of that write
    wr(10, 2'b10, 18'h3C1C3, "R4");     // byte a only
    rd(10, "R9");                       // merged forward
    wr(10, 2'b01, 18'h17E55, "R4");     // byte b only
    nop("R7");
    wr(11, 2'b00, 18'h01234, "R3");     // commits the byte b write
    nop("R7");
    rd(10, "R4");                       // from array, bytes merged
    wr(12, 2'b11, 18'h3FFFF, "R4");     // no byte enabled
    rd(12, "R4");
    nop("R4");
    settle();
  endtask

  task automatic t_b2b();
    wr(20, 2'b00, 18'h11111, "R10");
    wr(20, 2'b00, 18'h22222, "R10");
    wr(20, 2'b10, 18'h3ABCD, "R10");
    rd(20, "R10");
    wr(21, 2'b00, 18'h0F0F0, "R10");
    wr(22, 2'b00, 18'h30303, "R10");
    rd(20, "R10");
    rd(21, "R10");
    rd(22, "R10");
    nop("R10");
    settle();
  endtask

  task automatic t_interleave();
    wr(30, 2'b00, 18'h1AAAA, "R9");
    rd(31, "R9");
    wr(31, 2'b01, 18'h25555, "R9");
    rd(30, "R9");
    rd(31, "R9");
    wr(30, 2'b10, 18'h00077, "R9");
    rd(30, "R9");
    nop("R5");
    rd(0, "R2");
    nop("R5");
    settle();
  endtask

  task automatic t_oe();
    sel_n = 0; wr_n = 1; addr = 3; oe_n = 1; din = JUNK;
    tick();
    sel_n = 1;
    tick();
    check(dout_en === 1'b0, "R6", "dummy read", {17'b0, dout_en}, 18'd0);
    oe_n = 0; #1;
    check(dout_en === 1'b1, "R6", "oe async on", {17'b0, dout_en}, 18'd1);
    check(dout === model[3], "R6", "oe data", dout, model[3]);
    oe_n = 1; #1;
    check(dout_en === 1'b0, "R6", "oe async off", {17'b0, dout_en}, 18'd0);
    oe_n = 0;
    settle();
  endtask

  task automatic t_sleep();
    // sleep at address edge of a write
    sel_n = 0; wr_n = 0; bwa_n = 0; bwb_n = 0; addr = 5; sleep_i = 1;
    tick();
    sleep_i = 0; sel_n = 1; din = 18'h3DEAD;
    tick();
    // sleep at data edge of a write
    sel_n = 0; wr_n = 0; addr = 6;
    tick();
    sel_n = 1; din = 18'h2BEEF; sleep_i = 1;
    #1;
    check(dout_en === 1'b0, "R8", "sleep quiet", {17'b0, dout_en}, 18'd0);
    tick();
    sleep_i = 0;
    // flush any pending entry so the array holds everything
    ck_kind = 0; pw_v = 0;
    wr(40, 2'b00, 18'h00001, "R8");
    wr(41, 2'b00, 18'h00002, "R8");
    nop("R8");
    rd(5, "R8");
    rd(6, "R8");
    nop("R8");
    ck_kind = 0;
    // sleep cuts drive of a live output at once
    sel_n = 0; wr_n = 1; addr = 7;
    tick();
    sel_n = 1;
    tick();
    check(dout_en === 1'b1, "R8", "drive before sleep", {17'b0, dout_en}, 18'd1);
    sleep_i = 1; #1;
    check(dout_en === 1'b0, "R8", "sleep async", {17'b0, dout_en}, 18'd0);
    sleep_i = 0;
    settle();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    check(dout_en === 1'b0, "R1", "in reset", {17'b0, dout_en}, 18'd0);
    rst = 0;
    t_reset();
    t_basic();
    t_forward();
    t_b2b();
    t_interleave();
    t_oe();
    t_sleep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule